// File: doc/BRIEF.md
# Serial Flash Identification Prober

This block identifies an unknown serial flash device by driving an SPI master port on its own. After a start pulse it may first send a one-byte reset frame and pause. It then opens an identification frame, sends the read-identification opcode and clocks the response in one byte at a time. Unlike a fixed three-byte read, it adapts to the device. Leading filler bytes are counted and discarded, then manufacturer bank-continuation codes are counted and discarded. After that it captures the manufacturer code and the two device bytes that follow.

The measured filler count is brought out so that later command sequencers can reuse it as their delay setting. The bank number and the three identification bytes go to whatever logic picks the device. A bounded skip budget ends the probe with an error when no device answers, so an empty socket cannot hang the block. The SPI clock is derived from the system clock by an even divider.

States: `ST_IDLE` (waiting; `start` leads to `ST_RST_SETUP` when `reset_en` is set, else to `ST_ID_SETUP`), `ST_RST_SETUP` (chip select low for half an SCLK period, then the reset byte starts), `ST_RST_XFER` (reset byte on the wire, ends on byte done), `ST_RST_HOLD` (half-period hold, then chip select rises), `ST_GAP` (chip select high for `wait_cycles` clocks), `ST_ID_SETUP` (half-period setup, then the opcode starts), `ST_OP_XFER` (opcode on the wire, at byte done the first response byte starts), `ST_RSP_XFER` (each received byte is classified; another byte starts, or the frame ends after the second device byte or on an abort), `ST_END_HOLD` (half-period hold, then back to `ST_IDLE` with `done`).

Top module: `jedec_id_probe`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `busy`, `done` and `err` are 0, `dummy_cnt`, `mfr_id`, `dev_type` and `dev_cap` are 0 and `bank` is 1.
- R2: The bus runs in SPI mode 0, MSB first. SCLK idles low and is never high while `cs_n` is high. The identification frame sends opcode 0x9F and then drives 0x00 on `mosi` for every response byte, with `cs_n` held low for the whole frame. `miso` is sampled on the rising SCLK edge.
- R3: With `reset_en`=1 a separate frame carrying only byte 0xFF comes before the identification frame. `cs_n` stays high for at least `wait_cycles` clocks between the two frames. With `reset_en`=0 only the identification frame is sent.
- R4: While no 0x7F has been received, each received 0x00 or 0xFF is skipped and adds one to `dummy_cnt`.
- R5: Each received 0x7F ahead of the manufacturer code is skipped and adds one to the continuation count. `bank` equals that count plus one.
- R6: A 0x00 or 0xFF received after at least one 0x7F ends the frame at once with `err`=1, leaving `mfr_id`, `dev_type` and `dev_cap` at 0.
- R7: The first received byte that is not 0x00, 0xFF or 0x7F goes to `mfr_id`. The next two go to `dev_type` and `dev_cap`, and then the frame ends. The frame is then 1 + skipped + 3 bytes long, and `err`=0.
- R8: At most MAX_SKIP (default 16) bytes are skipped in total. A byte that would be skipped beyond that ends the frame with `err`=1, and the counts stay at their values before that byte.
- R9: `done` is a one-cycle pulse in the first cycle with `busy`=0. All result outputs hold from then until the next accepted start.
- R10: A `start` pulse while `busy`=1 is ignored: no extra frame is sent and the result is unchanged.
- R11: `cs_n` falls at least CLK_DIV/2 clocks before the first rising SCLK edge of a frame. It rises at least CLK_DIV/2 clocks after the last falling SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (accepted only when idle) |
| reset_en | input | 1 | Send the 0xFF reset frame first |
| wait_cycles | input | WAIT_W | Clocks of chip-select-high gap after the reset frame |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Probe aborted |
| dummy_cnt | output | CNT_W | Number of filler bytes skipped |
| bank | output | CNT_W | Manufacturer bank, continuation count plus one |
| mfr_id | output | 8 | Manufacturer code |
| dev_type | output | 8 | First device byte |
| dev_cap | output | 8 | Second device byte |

## Verification
`busy` rises on the clock edge that takes `start`, so the bench looks at it on the falling edge right after the start pulse. `done` and the final results appear one clock after the closing half-period of `ST_END_HOLD`. The bench therefore polls `done` on falling clock edges and reads every result in that same cycle, then reads them again one cycle and ten cycles later to confirm the pulse width and the hold. On the wire the device model changes `miso` on falling SCLK edges, half a period before the sampling rising edge. It counts bytes and measures chip-select setup, hold and gap times against the frame expected from the programmed response.

// File: rtl/jid_pkg.sv
`timescale 1ns/1ps
package jid_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_SETUP,
        ST_RST_XFER,
        ST_RST_HOLD,
        ST_GAP,
        ST_ID_SETUP,
        ST_OP_XFER,
        ST_RSP_XFER,
        ST_END_HOLD
    } jid_state_e;

    typedef enum logic [1:0] {
        BK_FILL,
        BK_CONT,
        BK_DATA
    } byte_kind_e;

    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_READ_ID = 8'h9F;
    localparam logic [7:0] CODE_CONT  = 8'h7F;
    localparam logic [7:0] TX_IDLE    = 8'h00;

    function automatic byte_kind_e classify(input logic [7:0] b);
        if (b == 8'h00 || b == 8'hFF) return BK_FILL;
        if (b == CODE_CONT)           return BK_CONT;
        return BK_DATA;
    endfunction

endpackage

// File: rtl/jid_tick.sv
`timescale 1ns/1ps
module jid_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/jid_shift.sv
`timescale 1ns/1ps
module jid_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    logic       active_q;
    logic       sclk_q;
    logic [7:0] txs_q;
    logic [7:0] rxs_q;
    logic [2:0] bit_q;

    assign sclk = sclk_q;
    assign mosi = active_q ? txs_q[7] : 1'b0;
    assign rx   = rxs_q;
    assign done = active_q && tick && sclk_q && (bit_q == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            txs_q    <= '0;
            rxs_q    <= '0;
            bit_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            txs_q    <= tx;
            bit_q    <= '0;
        end else if (active_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rxs_q  <= {rxs_q[6:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    txs_q <= {txs_q[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/jedec_id_probe.sv
`timescale 1ns/1ps
module jedec_id_probe
    import jid_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int MAX_SKIP = 16,
    parameter int WAIT_W   = 16,
    localparam int HALF    = CLK_DIV / 2,
    localparam int CNT_W   = $clog2(MAX_SKIP + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reset_en,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  dummy_cnt,
    output logic [CNT_W-1:0]  bank,
    output logic [7:0]        mfr_id,
    output logic [7:0]        dev_type,
    output logic [7:0]        dev_cap
);
    jid_state_e state_q, state_d;

    logic              tick, clr_tick;
    logic              go, xfer_done;
    logic [7:0]        tx_byte, rx;
    logic [WAIT_W-1:0] wait_q;
    logic [CNT_W-1:0]  dummy_q, cont_q;
    logic [CNT_W:0]    skip_tot;
    logic              skip_full;
    logic [1:0]        idx_q;
    logic              err_q, done_q;
    logic [7:0]        mfr_q, typ_q, cap_q;
    logic              ev_fill, ev_cont, ev_mfr, ev_typ, ev_cap, ev_abort;

    assign clr_tick  = (state_q != state_d);
    assign skip_tot  = {1'b0, dummy_q} + {1'b0, cont_q};
    assign skip_full = (skip_tot >= (CNT_W + 1)'(MAX_SKIP));

    jid_tick #(.HALF(HALF)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_tick),
        .tick  (tick)
    );

    jid_shift shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .go    (go),
        .tx    (tx_byte),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .rx    (rx),
        .done  (xfer_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state, byte launch and response classification
    always_comb begin
        state_d  = state_q;
        go       = 1'b0;
        tx_byte  = TX_IDLE;
        ev_fill  = 1'b0;
        ev_cont  = 1'b0;
        ev_mfr   = 1'b0;
        ev_typ   = 1'b0;
        ev_cap   = 1'b0;
        ev_abort = 1'b0;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = reset_en ? ST_RST_SETUP : ST_ID_SETUP;
            ST_RST_SETUP: if (tick) begin
                              go      = 1'b1;
                              tx_byte = OP_RESET;
                              state_d = ST_RST_XFER;
                          end
            ST_RST_XFER:  if (xfer_done) state_d = ST_RST_HOLD;
            ST_RST_HOLD:  if (tick) state_d = ST_GAP;
            ST_GAP:       if (wait_q >= wait_cycles) state_d = ST_ID_SETUP;
            ST_ID_SETUP:  if (tick) begin
                              go      = 1'b1;
                              tx_byte = OP_READ_ID;
                              state_d = ST_OP_XFER;
                          end
            ST_OP_XFER:   if (xfer_done) begin
                              go      = 1'b1;
                              state_d = ST_RSP_XFER;
                          end
            ST_RSP_XFER:  if (xfer_done) begin
                              if (idx_q == 2'd0) begin
                                  unique case (classify(rx))
                                      BK_FILL: if (cont_q != '0 || skip_full) ev_abort = 1'b1;
                                               else ev_fill = 1'b1;
                                      BK_CONT: if (skip_full) ev_abort = 1'b1;
                                               else ev_cont = 1'b1;
                                      BK_DATA: ev_mfr = 1'b1;
                                      default: ev_abort = 1'b1;
                                  endcase
                              end else if (idx_q == 2'd1) begin
                                  ev_typ = 1'b1;
                              end else begin
                                  ev_cap = 1'b1;
                              end
                              if (ev_abort || ev_cap) state_d = ST_END_HOLD;
                              else                    go = 1'b1;
                          end
            ST_END_HOLD:  if (tick) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Results, counters and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q  <= '0;
            dummy_q <= '0;
            cont_q  <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            mfr_q   <= '0;
            typ_q   <= '0;
            cap_q   <= '0;
        end else begin
            done_q <= (state_q == ST_END_HOLD) && tick;
            wait_q <= (state_q == ST_GAP) ? wait_q + 1'b1 : '0;
            if (state_q == ST_IDLE && start) begin
                dummy_q <= '0;
                cont_q  <= '0;
                idx_q   <= '0;
                err_q   <= 1'b0;
                mfr_q   <= '0;
                typ_q   <= '0;
                cap_q   <= '0;
            end
            if (ev_fill)  dummy_q <= dummy_q + 1'b1;
            if (ev_cont)  cont_q  <= cont_q + 1'b1;
            if (ev_mfr)   begin mfr_q <= rx; idx_q <= 2'd1; end
            if (ev_typ)   begin typ_q <= rx; idx_q <= 2'd2; end
            if (ev_cap)   cap_q <= rx;
            if (ev_abort) err_q <= 1'b1;
        end
    end

    assign cs_n      = !(state_q inside {ST_RST_SETUP, ST_RST_XFER, ST_RST_HOLD,
                                         ST_ID_SETUP, ST_OP_XFER, ST_RSP_XFER, ST_END_HOLD});
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign dummy_cnt = dummy_q;
    assign bank      = cont_q + CNT_W'(1);
    assign mfr_id    = mfr_q;
    assign dev_type  = typ_q;
    assign dev_cap   = cap_q;
endmodule

// File: rtl/jid_checker.sv
`timescale 1ns/1ps
module jid_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sclk,
    input logic             cs_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] dummy_cnt,
    input logic [CNT_W-1:0] bank,
    input logic [7:0]       mfr_id
);
    // R2: the serial clock stays low outside a frame
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5: bank numbering never reads zero
    assert_bank_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bank != '0);

    // R9: completion is a single-cycle pulse seen only when idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: results hold while idle and no start arrives
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mfr_id) && $stable(dummy_cnt) && $stable(bank) && $stable(err)));

    // R10: a probe only begins in response to a start pulse
    assert_start_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind jedec_id_probe jid_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .dummy_cnt (dummy_cnt),
    .bank      (bank),
    .mfr_id    (mfr_id)
);

// File: tb/jedec_id_probe_tb_top.sv
`timescale 1ns/1ps
module jedec_id_probe_tb_top;
    localparam int CLK_DIV  = 4;
    localparam int MAX_SKIP = 16;
    localparam int WAIT_W   = 16;
    localparam int HALF     = CLK_DIV / 2;
    localparam int CNT_W    = $clog2(MAX_SKIP + 2);
    localparam int PER_NS   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic reset_en = 1'b0;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic miso = 1'b0;
    logic sclk, mosi, cs_n, busy, done, err;
    logic [CNT_W-1:0] dummy_cnt, bank;
    logic [7:0] mfr_id, dev_type, dev_cap;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    jedec_id_probe #(.CLK_DIV(CLK_DIV), .MAX_SKIP(MAX_SKIP), .WAIT_W(WAIT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .reset_en(reset_en),
        .wait_cycles(wait_cycles), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy), .done(done), .err(err), .dummy_cnt(dummy_cnt),
        .bank(bank), .mfr_id(mfr_id), .dev_type(dev_type), .dev_cap(dev_cap)
    );

    // ---------------- device model ----------------
    logic [7:0] resp [0:39];
    int resp_len = 0;
    logic [7:0] fill_byte = 8'hFF;

    int frame_cnt = 0;
    int rise_bits = 0;
    int fall_bits = 0;
    logic [7:0] mosi_sr = '0;
    logic [7:0] last_op = '0, prev_op = '0;
    int last_bytes = 0, prev_bytes = 0;
    bit mosi_bad = 0;
    longint t_cs_fall = 0, t_cs_rise = 0, t_last_fall = 0;
    longint setup_ns = 0, hold_ns = 0, gap_ns = 0;

    function automatic logic [7:0] stream_byte(input int k);
        if (k < resp_len) return resp[k];
        return fill_byte;
    endfunction

    function automatic logic stream_bit(input int p);
        int bi = p / 8;
        int bk = 7 - (p % 8);
        logic [7:0] b;
        if (bi == 0) return 1'b0;
        b = stream_byte(bi - 1);
        return b[bk];
    endfunction

    always @(negedge cs_n) begin
        if (frame_cnt > 0) gap_ns = $time - t_cs_rise;
        frame_cnt = frame_cnt + 1;
        rise_bits = 0;
        fall_bits = 0;
        t_cs_fall = $time;
        miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rise_bits == 0) setup_ns = $time - t_cs_fall;
            mosi_sr = {mosi_sr[6:0], mosi};
            rise_bits = rise_bits + 1;
            if (rise_bits % 8 == 0) begin
                if (rise_bits == 8) begin
                    prev_op = last_op;
                    last_op = mosi_sr;
                end else if (mosi_sr != 8'h00) begin
                    mosi_bad = 1;
                end
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            fall_bits = fall_bits + 1;
            t_last_fall = $time;
            miso = stream_bit(fall_bits);
        end
    end

    always @(posedge cs_n) begin
        if (frame_cnt > 0) begin
            hold_ns = $time - t_last_fall;
            t_cs_rise = $time;
            prev_bytes = last_bytes;
            last_bytes = rise_bits / 8;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_resp();
        resp_len = 0;
        fill_byte = 8'hFF;
    endtask

    task automatic push(input logic [7:0] b);
        resp[resp_len] = b;
        resp_len++;
    endtask

    // Expected result computed from the requirements
    task automatic model(output bit e_err, output int e_d, output int e_c, output int e_m,
                         output int e_t, output int e_cap, output int e_bytes);
        int i = 0;
        int idx = 0;
        logic [7:0] b;
        e_err = 0; e_d = 0; e_c = 0; e_m = 0; e_t = 0; e_cap = 0;
        forever begin
            b = stream_byte(i);
            i++;
            if (idx == 0) begin
                if (b == 8'h00 || b == 8'hFF) begin
                    if (e_c > 0 || e_d + e_c >= MAX_SKIP) begin e_err = 1; break; end
                    e_d++;
                end else if (b == 8'h7F) begin
                    if (e_d + e_c >= MAX_SKIP) begin e_err = 1; break; end
                    e_c++;
                end else begin
                    e_m = b; idx = 1;
                end
            end else if (idx == 1) begin
                e_t = b; idx = 2;
            end else begin
                e_cap = b; break;
            end
        end
        e_bytes = 1 + i;
    endtask

    task automatic probe(input bit rst_en, input int wt, input bit extra_start);
        bit e_err;
        int e_d, e_c, e_m, e_t, e_cap, e_bytes;
        int f0 = frame_cnt;
        int n = 0;
        bit seen = 0;
        model(e_err, e_d, e_c, e_m, e_t, e_cap, e_bytes);
        @(negedge clk);
        reset_en = rst_en;
        wait_cycles = WAIT_W'(wt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", busy, 1);
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (n < 20000 && !seen) begin
            if (done) seen = 1;
            else begin @(negedge clk); n++; end
        end
        check("R9", "done seen", seen, 1);
        check("R9", "busy low with done", busy, 0);
        check("R6/R8", "err", err, e_err);
        check("R4", "dummy_cnt", dummy_cnt, e_d);
        check("R5", "bank", bank, e_c + 1);
        check("R7", "mfr_id", mfr_id, e_m);
        check("R7", "dev_type", dev_type, e_t);
        check("R7", "dev_cap", dev_cap, e_cap);
        check("R7", "id frame bytes", last_bytes, e_bytes);
        check("R2", "id opcode", last_op, 8'h9F);
        check("R2", "mosi idle bytes nonzero", mosi_bad, 0);
        check("R11", "cs setup ok", (setup_ns >= HALF * PER_NS), 1);
        check("R11", "cs hold ok", (hold_ns >= HALF * PER_NS), 1);
        check("R3", "frame count", frame_cnt - f0, rst_en ? 2 : 1);
        if (rst_en) begin
            check("R3", "reset opcode", prev_op, 8'hFF);
            check("R3", "reset frame bytes", prev_bytes, 1);
            check("R3", "gap ok", (gap_ns >= longint'(wt) * PER_NS), 1);
        end
        @(negedge clk);
        check("R9", "done width", done, 0);
        resp[0] = 8'h3C;
        fill_byte = 8'h5A;
        repeat (10) @(negedge clk);
        check("R9", "mfr held", mfr_id, e_m);
        check("R9", "dummy held", dummy_cnt, e_d);
        check("R10", "no extra frame", frame_cnt - f0, rst_en ? 2 : 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int unsigned sd;
        sd = $urandom(32'd13579);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cs_n", cs_n, 1);
        check("R1", "sclk", sclk, 0);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "err", err, 0);
        check("R1", "dummy_cnt", dummy_cnt, 0);
        check("R1", "bank", bank, 1);
        check("R1", "mfr_id", mfr_id, 0);

        // R7 plain device, no filler
        clear_resp(); push(8'hEF); push(8'h40); push(8'h18);
        probe(0, 0, 0);
        // R4 one filler byte
        clear_resp(); push(8'h00); push(8'hEF); push(8'hAA); push(8'h21);
        probe(0, 0, 0);
        // R4 R5 mixed filler and continuation, with reset frame (R3)
        clear_resp(); push(8'hFF); push(8'h00); push(8'hFF); push(8'h7F); push(8'h7F);
        push(8'h85); push(8'h60); push(8'h13);
        probe(1, 10, 0);
        // R6 filler after continuation
        clear_resp(); push(8'h7F); push(8'h00); push(8'h12);
        probe(0, 0, 0);
        // R8 no device: all ones
        clear_resp();
        probe(0, 0, 0);
        // R8 exactly MAX_SKIP skipped is accepted
        clear_resp();
        for (int i = 0; i < MAX_SKIP; i++) push(8'h00);
        push(8'hC2); push(8'h20); push(8'h17);
        probe(1, 0, 0);
        // R8 continuation beyond the budget
        clear_resp();
        for (int i = 0; i < MAX_SKIP + 1; i++) push(8'h7F);
        probe(0, 0, 0);
        // R10 second start while busy
        clear_resp(); push(8'h00); push(8'h9D); push(8'h70); push(8'h16);
        probe(0, 0, 1);

        // random streams
        for (int it = 0; it < 20; it++) begin
            int nd = int'($urandom % 5);
            int nc = int'($urandom % 3);
            logic [7:0] m;
            clear_resp();
            for (int k = 0; k < nd; k++) push(($urandom % 2) ? 8'hFF : 8'h00);
            for (int k = 0; k < nc; k++) push(8'h7F);
            if (nc > 0 && ($urandom % 4) == 0) push(8'h00);
            do m = 8'($urandom); while (m == 8'h00 || m == 8'hFF || m == 8'h7F);
            push(m); push(8'($urandom)); push(8'($urandom));
            probe(bit'($urandom % 2), int'($urandom % 8), 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule